// File: doc/BRIEF.md
# Programmable Raster Timing Generator

The block turns a pixel clock into the horizontal and vertical timing of a display raster. Software writes the sync, back porch, active and front porch lengths for both axes into a small register file over a synchronous write/read port. The generator then drives horizontal sync, vertical sync and active-video outputs, and a pixel-request strobe that tells the upstream pixel source to supply the next pixel one cycle ahead. Frames can be progressive or interlaced. In interlaced mode the even field comes first and uses its own vertical register pair. The odd field moves its vertical sync edges later by a programmable number of clocks.

All horizontal lengths are in output clocks. When pixel repetition is on, each pixel is held for two clocks, so the request strobe fires on every other active clock only. A sticky status bit is set at the first line of the vertical front porch. It is cleared by writing 1 and reaches the interrupt pin only while its enable bit is set. Scanout is started by a video-enable bit and needs the global enable to be set as well. Clearing video-enable lets the current frame finish. Clearing the global enable, or writing the pipeline-clear bit, stops the generator at once.

Top module: `scan_timing_gen`

Register map (address: contents). Lengths are HW bits wide. "lo" means bits HW-1:0 and "hi" means bits 2HW-1:HW.
- 0 control: bit0 global enable, bit1 pipeline clear (write-only pulse, reads 0), bit2 repetition factor minus one
- 1 video control: bit0 video enable (reads 1 while a frame is still running), bit1 continuous, bit2 interlace, bit3 serial-count mode
- 2 horizontal A: lo sync width, hi back porch
- 3 horizontal B: lo active width, hi front porch
- 4 vertical A: lo sync lines, hi back porch lines
- 5 vertical B: lo active lines, hi front porch lines
- 6 and 7: even-field copies of 4 and 5
- 8: odd-field vsync delay in clocks
- 9: bit0 interrupt enable
- 10: bit0 front-porch status (write 1 to clear)
- 11: serial active-pixel count

## Requirements
- R1: After reset, hsync, vsync, active video, pixel request and interrupt are all 0, and the video-control readback and the status bit read 0.
- R2: Each line is sync, then back porch, then active, then front porch clocks; each frame is sync, back porch, active and front porch lines. Frame length, sync and active counts follow the register values. Sync outputs are active high.
- R3: With repetition (control bit2 = 1) the pixel request fires only on even offsets into the active span: ceil(active/2) requests per active line.
- R4: The pixel request is high in the clock just before an active pixel, never in the clock of the last active pixel, and starts one clock before active video first rises on a line.
- R5: The status bit is set on the first clock of the first front porch line. The interrupt rises in the clock after that position.
- R6: The interrupt is the status bit gated by the enable bit (address 9 bit0). Writing 0 to address 10 leaves the status bit alone, and writing 1 clears it.
- R7: If a write of 1 to the status bit falls in the same cycle as the set event, the bit stays set.
- R8: Clearing video enable mid-frame lets the frame run to its end. Video enable reads back 1 until the generator is idle, then 0.
- R9: With continuous = 0 the generator produces exactly one frame and then reads back video enable as 0. With continuous = 1 frames repeat.
- R10: Writing control with enable = 0, or with the clear bit set, stops output in the next cycle and drops the video-enable request. The sequence 0, clear|enable, 0 leaves the generator idle. A later start produces a full frame from the top.
- R11: In interlaced mode the first field uses the even-field vertical registers (6, 7). Fields then alternate with the main registers (4, 5).
- R12: In the odd field both vsync edges are delayed by the value at address 8. The pulse width stays equal to the sync lines times the line length.
- R13: In serial-count mode (video control bit3) the pixel request covers only the first N active pixels of a line, where N is the smaller of address 11 and the active width. Active video is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wr_en | input | 1 | register write strobe |
| addr | input | AW | register address for write and read |
| wdata | input | 2*HW | write data |
| rdata | output | 2*HW | read data, registered one cycle after addr |
| hsync | output | 1 | horizontal sync, active high |
| vsync | output | 1 | vertical sync, active high |
| de | output | 1 | active video |
| pix_req | output | 1 | request for the next pixel |
| irq | output | 1 | front-porch interrupt |

## Verification
The status bit has two writers: the front-porch set event and the software write-one-to-clear. Both can land in the same clock. The bench counts clocks from a vsync rising edge to the set position and places a clear write on exactly that edge. The interrupt must still be high afterwards. The same count, taken one frame earlier, checks that a clear away from the set event drops the interrupt. A second overlap is a video-enable clear arriving mid-frame. It is judged by the readback staying 1 and by hsync still being present at a late line.

// File: rtl/scan_timing_gen.sv
module scan_timing_gen #(
  parameter int HW = 12,
  parameter int AW = 4
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [2*HW-1:0] wdata,
  output logic [2*HW-1:0] rdata,
  output logic            hsync,
  output logic            vsync,
  output logic            de,
  output logic            pix_req,
  output logic            irq
);
  localparam int DW = 2 * HW;
  localparam int TW = HW + 2;
  localparam logic [AW-1:0] A_CTL = AW'(0), A_VCTL = AW'(1), A_HA = AW'(2), A_HB = AW'(3),
                            A_VA = AW'(4), A_VB = AW'(5), A_VAE = AW'(6), A_VBE = AW'(7),
                            A_ODLY = AW'(8), A_IEN = AW'(9), A_IST = AW'(10), A_ACNT = AW'(11);

  logic          ctl_en, ctl_rep, vid_req, cont, ilace, serial, ien, istat, running, odd_f;
  logic [DW-1:0] ha, hb, va, vb, vae, vbe, vsel_a, vsel_b, rd_mux;
  logic [TW-1:0] odly, hpos, vpos;
  logic [HW-1:0] acnt;
  logic [TW-1:0] h_s, h_a0, h_a1, h_t, h_act, v_s, v_a0, v_a1, v_t, dly, nxt, off, lim;
  logic          use_even, line_act, hend, vend, set_ev, halt;

  assign use_even = ilace && !odd_f;
  assign vsel_a   = use_even ? vae : va;
  assign vsel_b   = use_even ? vbe : vb;

  assign h_s   = TW'(ha[HW-1:0]);
  assign h_act = TW'(hb[HW-1:0]);
  assign h_a0  = h_s + TW'(ha[DW-1:HW]);
  assign h_a1  = h_a0 + h_act;
  assign h_t   = h_a1 + TW'(hb[DW-1:HW]);
  assign v_s   = TW'(vsel_a[HW-1:0]);
  assign v_a0  = v_s + TW'(vsel_a[DW-1:HW]);
  assign v_a1  = v_a0 + TW'(vsel_b[HW-1:0]);
  assign v_t   = v_a1 + TW'(vsel_b[DW-1:HW]);

  assign dly = (ilace && odd_f) ? odly : '0;
  assign nxt = hpos + TW'(1);
  assign off = nxt - h_a0;
  assign lim = (serial && TW'(acnt) < h_act) ? TW'(acnt) : h_act;

  assign line_act = vpos >= v_a0 && vpos < v_a1;
  assign hend     = hpos == h_t - TW'(1);
  assign vend     = vpos == v_t - TW'(1);
  assign set_ev   = running && hpos == '0 && vpos == v_a1;
  assign halt     = wr_en && addr == A_CTL && (!wdata[0] || wdata[1]);

  assign hsync   = running && hpos < h_s;
  assign vsync   = running && ((vpos == '0 && hpos >= dly) ||
                               (vpos != '0 && vpos < v_s) ||
                               (vpos == v_s && hpos < dly));
  assign de      = running && line_act && hpos >= h_a0 && hpos < h_a1;
  assign pix_req = running && line_act && nxt >= h_a0 && off < lim && !(ctl_rep && off[0]);
  assign irq     = istat && ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_rep <= 1'b0; vid_req <= 1'b0; cont <= 1'b0;
      ilace <= 1'b0; serial <= 1'b0; ien <= 1'b0; istat <= 1'b0;
      running <= 1'b0; odd_f <= 1'b0;
      ha <= '0; hb <= '0; va <= '0; vb <= '0; vae <= '0; vbe <= '0;
      odly <= '0; acnt <= '0; hpos <= '0; vpos <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTL:  begin ctl_en <= wdata[0]; ctl_rep <= wdata[2]; end
          A_VCTL: begin cont <= wdata[1]; ilace <= wdata[2]; serial <= wdata[3]; end
          A_HA:   ha <= wdata;
          A_HB:   hb <= wdata;
          A_VA:   va <= wdata;
          A_VB:   vb <= wdata;
          A_VAE:  vae <= wdata;
          A_VBE:  vbe <= wdata;
          A_ODLY: odly <= wdata[TW-1:0];
          A_IEN:  ien <= wdata[0];
          A_ACNT: acnt <= wdata[HW-1:0];
          default: ;
        endcase
      end

      if (running) begin
        if (hend) begin
          hpos <= '0;
          if (vend) begin
            vpos <= '0;
            if (vid_req && cont) odd_f <= ilace && !odd_f;
            else begin
              running <= 1'b0;
              if (!cont) vid_req <= 1'b0;
            end
          end else vpos <= vpos + TW'(1);
        end else hpos <= nxt;
      end else if (vid_req && ctl_en) begin
        running <= 1'b1;
        hpos    <= '0;
        vpos    <= '0;
        odd_f   <= 1'b0;
      end

      if (wr_en && addr == A_VCTL) vid_req <= wdata[0];

      if (wr_en && addr == A_IST && wdata[0]) istat <= 1'b0;
      if (set_ev) istat <= 1'b1;

      if (halt) begin
        running <= 1'b0;
        vid_req <= 1'b0;
        odd_f   <= 1'b0;
        hpos    <= '0;
        vpos    <= '0;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CTL:  rd_mux = DW'({ctl_rep, 1'b0, ctl_en});
      A_VCTL: rd_mux = DW'({serial, ilace, cont, vid_req || running});
      A_HA:   rd_mux = ha;
      A_HB:   rd_mux = hb;
      A_VA:   rd_mux = va;
      A_VB:   rd_mux = vb;
      A_VAE:  rd_mux = vae;
      A_VBE:  rd_mux = vbe;
      A_ODLY: rd_mux = DW'(odly);
      A_IEN:  rd_mux = DW'(ien);
      A_IST:  rd_mux = DW'(istat);
      A_ACNT: rd_mux = DW'(acnt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd_mux;
  end
endmodule

// File: rtl/scan_timing_gen_chk.sv
module scan_timing_gen_chk #(
  parameter int AW = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] addr,
  input logic          wd0,
  input logic          hsync,
  input logic          vsync,
  input logic          de,
  input logic          pix_req,
  input logic          irq,
  input logic          run
);
  localparam logic [AW-1:0] C_CTL = AW'(0), C_IEN = AW'(9), C_IST = AW'(10);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!hsync && !vsync && !de && !pix_req));

  a_r2_sync_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> !hsync);

  a_r4_req_leads_active: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(de) |-> $past(pix_req));

  a_r6_irq_drop_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && (addr == C_IEN || addr == C_IST)));

  a_r5_irq_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(run) || $past(wr_en && addr == C_IEN)));

  a_r10_stop_next: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_CTL && !wd0) |=> !run);
endmodule

bind scan_timing_gen scan_timing_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wd0(wdata[0]),
  .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req), .irq(irq), .run(running)
);

// File: tb/sim_scan_timing_gen.sv
`timescale 1ns/1ps
module sim_scan_timing_gen;
  localparam int HW = 12;
  localparam int AW = 4;
  localparam int DW = 2 * HW;

  // hs hb ha hf vs vb va vf rep | frame de preq hsync vsync
  localparam int TV [4][14] = '{
    '{2, 3, 8, 2, 1, 2, 4, 1, 0, 120, 32, 32, 16, 15},
    '{4, 2, 10, 4, 2, 1, 3, 2, 1, 160, 30, 15, 32, 40},
    '{1, 1, 1, 1, 1, 1, 1, 1, 0, 16, 1, 1, 4, 4},
    '{1, 2, 3, 1, 1, 1, 2, 1, 1, 35, 6, 4, 5, 7}
  };

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic hsync, vsync, de, pix_req, irq;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  scan_timing_gen #(.HW(HW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .hsync(hsync), .vsync(vsync), .de(de), .pix_req(pix_req), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; addr = AW'(a); wdata = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic wait_vrise();
    logic prev = vsync;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (vsync && !prev) return;
      prev = vsync;
    end
    check("watchdog vsync", 0, 1);
  endtask

  task automatic count_to_rise(output int fr, output int hs, output int vs, output int dc, output int pr);
    logic prevv;
    fr = 0; hs = 0; vs = 0; dc = 0; pr = 0;
    for (int n = 0; n < 5000; n++) begin
      fr++; hs += int'(hsync); vs += int'(vsync); dc += int'(de); pr += int'(pix_req);
      prevv = vsync;
      @(negedge clk);
      if (vsync && !prevv) return;
    end
    check("watchdog frame", 0, 1);
  endtask

  task automatic quiet_for(input string req, input int n);
    int act = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      act += int'(hsync || vsync || de || pix_req);
    end
    check(req, act, 0);
  endtask

  task automatic prog(input int i);
    wr(2, (TV[i][1] << HW) | TV[i][0]);
    wr(3, (TV[i][3] << HW) | TV[i][2]);
    wr(4, (TV[i][5] << HW) | TV[i][4]);
    wr(5, (TV[i][7] << HW) | TV[i][6]);
  endtask

  initial begin
    #(8 * 190000);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int fr, hs, vs, dc, pr, r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs", int'({hsync, vsync, de, pix_req, irq}), 0);
    rd(1, r); check("R1 video readback", r, 0);
    rd(10, r); check("R1 status", r, 0);

    for (int i = 0; i < 4; i++) begin
      prog(i);
      wr(0, 1 | (TV[i][8] << 2));
      wr(1, 3);
      wait_vrise();
      count_to_rise(fr, hs, vs, dc, pr);
      check($sformatf("R2 frame v%0d", i), fr, TV[i][9]);
      check($sformatf("R2 active v%0d", i), dc, TV[i][10]);
      check($sformatf("R3 preq v%0d", i), pr, TV[i][11]);
      check($sformatf("R2 hsync v%0d", i), hs, TV[i][12]);
      check($sformatf("R2 vsync v%0d", i), vs, TV[i][13]);
      wr(0, 0);
    end

    prog(0);
    wr(9, 1);
    wr(0, 1);
    wr(1, 3);
    wait_vrise();
    repeat (49) @(negedge clk);
    check("R4 preq before first pixel", int'({pix_req, de}), 2);
    @(negedge clk);
    check("R4 active follows", int'(de), 1);
    repeat (7) @(negedge clk);
    check("R4 no preq on last pixel", int'({pix_req, de}), 1);

    wait_vrise();
    wr(10, 1);
    repeat (104) @(negedge clk);
    check("R5 irq low before vfp", int'(irq), 0);
    @(negedge clk);
    check("R5 irq at vfp start", int'(irq), 1);
    wr(9, 0);
    check("R6 masked irq", int'(irq), 0);
    rd(10, r); check("R6 status kept", r, 1);
    wr(9, 1);
    check("R6 unmasked irq", int'(irq), 1);
    wr(10, 0);
    check("R6 write 0 keeps", int'(irq), 1);
    wr(10, 1);
    check("R6 write 1 clears", int'(irq), 0);

    wait_vrise();
    wr(10, 1);
    repeat (104) @(negedge clk);
    wr(10, 1);
    check("R7 set beats clear", int'(irq), 1);
    @(negedge clk);
    check("R7 stays set", int'(irq), 1);

    wait_vrise();
    repeat (20) @(negedge clk);
    wr(1, 2);
    rd(1, r); check("R8 readback while running", r & 1, 1);
    repeat (83) @(negedge clk);
    check("R8 frame continues", int'(hsync), 1);
    repeat (20) @(negedge clk);
    rd(1, r); check("R8 readback idle", r & 1, 0);
    quiet_for("R8 no next frame", 300);

    wr(1, 1);
    wait_vrise();
    repeat (125) @(negedge clk);
    rd(1, r); check("R9 single frame readback", r & 1, 0);
    quiet_for("R9 single frame only", 300);

    wr(1, 3);
    wait_vrise();
    repeat (30) @(negedge clk);
    wr(0, 0);
    check("R10 immediate stop", int'({hsync, vsync, de, pix_req}), 0);
    quiet_for("R10 stays stopped", 200);
    rd(1, r); check("R10 request dropped", r & 1, 0);
    wr(0, 1);
    quiet_for("R10 no restart on enable", 200);
    wr(1, 3);
    wait_vrise();
    repeat (10) @(negedge clk);
    wr(0, 0); wr(0, 3); wr(0, 0);
    quiet_for("R10 clear sequence idle", 200);
    wr(0, 1); wr(1, 3);
    wait_vrise();
    count_to_rise(fr, hs, vs, dc, pr);
    check("R10 clean restart frame", fr, 120);
    check("R10 clean restart hsync", hs, 16);

    wr(0, 0);
    wr(6, (1 << HW) | 1);
    wr(7, (1 << HW) | 4);
    wr(8, 7);
    wr(0, 1);
    wr(1, 7);
    wait_vrise();
    count_to_rise(fr, hs, vs, dc, pr);
    check("R11 even field first length", fr, 112);
    check("R11 even field active", dc, 32);
    check("R11 even vsync width", vs, 15);
    count_to_rise(fr, hs, vs, dc, pr);
    check("R12 odd field rise to even rise", fr, 113);
    check("R12 odd vsync width", vs, 15);

    wr(0, 0);
    wr(11, 5);
    wr(0, 1);
    wr(1, 11);
    wait_vrise();
    count_to_rise(fr, hs, vs, dc, pr);
    check("R13 serial preq count", pr, 20);
    check("R13 active unchanged", dc, 32);
    wr(0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule